// File: doc/BRIEF.md
# PWM Retrigger and Fault Input Conditioner

This block turns one external pin into clean control events for a PWM stage controller. The pin is picked from four candidates and synchronized into the clock domain. A polarity setting then maps it to an active-high internal level, and an optional agreement filter can clean it. A 4-bit mode field decides what the cleaned level is used for. It can be a fault level that the waveform generator obeys while it lasts. It can be a one-cycle retrigger pulse on each active edge, with a flag that tells the fixed-frequency variant apart. Or it can be nothing at all.

A separate capture enable turns each active edge into a one-cycle strobe for a timer capture register. The strobe does not depend on the mode. All configuration arrives as plain register inputs. Waveform generation, dead time and the capture register itself sit outside this block.

Top module: `pwm_event_cond`

## Requirements
- R1: With mode 0000, `fault_active` and `retrig_pulse` stay low whatever the selected pin does.
- R2: Mode values 1010 to 1111 act like mode 0000: no fault level and no retrigger pulse.
- R3: In modes 0001 to 0111, `fault_active` is high while the conditioned input is at its active level. With the filter off, a pin change driven before clock edge k shows on `fault_active` after edge k+2.
- R4: With `edge_pol` = 0, a low pin level and a falling edge are active. With `edge_pol` = 1, a high level and a rising edge are active.
- R5: In mode 1000 and mode 1001, each active edge gives exactly one cycle of `retrig_pulse`. `fixed_freq` is high exactly when mode is 1001.
- R6: With `filt_en` = 1, the conditioned level changes only after four successive synchronized samples agree on the new value. Pulses shorter than four cycles are suppressed, and accepted changes appear four cycles later than with the filter off.
- R7: With `cap_en` = 1, each active edge gives one cycle of `capture_strobe` in any mode, including 0000. With `cap_en` = 0, `capture_strobe` stays low.
- R8: The source index is {`src_sel_hi`, `src_sel_lo`}, and it selects `pin_in[index]`. The other pins have no effect.
- R9: During reset and afterwards, all event outputs are low while the selected pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Candidate external input pins |
| src_sel_lo | input | 1 | Low bit of the source index |
| src_sel_hi | input | 1 | High bit of the source index |
| edge_pol | input | 1 | 1: high/rising active, 0: low/falling active |
| filt_en | input | 1 | Enables the four-sample agreement filter |
| cap_en | input | 1 | Enables the capture strobe |
| mode | input | 4 | Event mode field |
| fault_active | output | 1 | Fault level (modes 1 to 7) |
| retrig_pulse | output | 1 | One-cycle retrigger pulse (modes 8, 9) |
| fixed_freq | output | 1 | High when mode is 9 |
| capture_strobe | output | 1 | One-cycle capture event |

## Verification
If the filter history or the synchronizer holds a wrong bit, the error shows at the ports as a fault level that arrives early, late or not at all. The worst case is a spurious fault or pulse right after reset, within the two or six cycles of pipeline latency. A stale edge-detector state shows up as a doubled or missing `retrig_pulse` and `capture_strobe` on the cycle after the edge. For this reason the bench checks the exact cycle of every event, and also the cycles on either side of it.

// File: rtl/pwm_event_cond.sv
module pwm_event_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pin_in,
  input  logic       src_sel_lo,
  input  logic       src_sel_hi,
  input  logic       edge_pol,
  input  logic       filt_en,
  input  logic       cap_en,
  input  logic [3:0] mode,
  output logic       fault_active,
  output logic       retrig_pulse,
  output logic       fixed_freq,
  output logic       capture_strobe
);
  localparam logic [3:0] MODE_RETRIG = 4'd8;
  localparam logic [3:0] MODE_FIXED  = 4'd9;

  logic [1:0]             src;
  logic                   raw_act;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   filt_q;
  logic                   prev_q;
  logic                   act_edge;
  logic                   is_fault;
  logic                   is_retrig;

  assign src     = {src_sel_hi, src_sel_lo};
  assign raw_act = pin_in[src] ~^ edge_pol;
  assign s       = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_act};
      hist_q <= {hist_q[FILT_LEN-2:0], s};
      prev_q <= filt_q;
      if (!filt_en)         filt_q <= s;
      else if (&hist_q)     filt_q <= 1'b1;
      else if (~|hist_q)    filt_q <= 1'b0;
    end
  end

  assign act_edge  = filt_q & ~prev_q;
  assign is_fault  = (mode[3] == 1'b0) && (mode != 4'd0);
  assign is_retrig = (mode == MODE_RETRIG) || (mode == MODE_FIXED);

  assign fault_active   = is_fault & filt_q;
  assign retrig_pulse   = is_retrig & act_edge;
  assign fixed_freq     = (mode == MODE_FIXED);
  assign capture_strobe = cap_en & act_edge;

  a_r1_mode0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |-> (!fault_active && !retrig_pulse));

  a_r2_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 4'd10) |-> (!fault_active && !retrig_pulse));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_pulse |=> !retrig_pulse);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    capture_strobe |=> !capture_strobe);

  a_r6_four_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_en) && $rose(filt_q)) |->
      ($past(s, 2) && $past(s, 3) && $past(s, 4) && $past(s, 5)));
endmodule

// File: tb/pwm_event_cond_tb.sv
`timescale 1ns/1ps
module pwm_event_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_in = 4'b0000;
  logic       src_sel_lo = 1'b0, src_sel_hi = 1'b0;
  logic       edge_pol = 1'b1, filt_en = 1'b0, cap_en = 1'b0;
  logic [3:0] mode = 4'd0;
  logic       fault_active, retrig_pulse, fixed_freq, capture_strobe;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int    due_q[$];
  logic [3:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_event_cond u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .src_sel_lo(src_sel_lo), .src_sel_hi(src_sel_hi),
    .edge_pol(edge_pol), .filt_en(filt_en), .cap_en(cap_en), .mode(mode),
    .fault_active(fault_active), .retrig_pulse(retrig_pulse),
    .fixed_freq(fixed_freq), .capture_strobe(capture_strobe)
  );

  wire [3:0] got = {fault_active, retrig_pulse, fixed_freq, capture_strobe};

  // monitor: pops expectations when due
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      n_chk++;
      if (due_q[0] != cyc || got !== exp_q[0]) begin
        n_bad++;
        $display("FAIL %s cyc=%0d got {flt,rtg,fix,cap}=%b expected %b",
                 tag_q[0], cyc, got, exp_q[0]);
      end
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  task automatic expect_out(int d, logic [3:0] e, string tag);
    due_q.push_back(cyc + d); exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg(logic [3:0] m, logic pol, logic flt, logic cap, logic [1:0] sel);
    mode = m; edge_pol = pol; filt_en = flt; cap_en = cap;
    {src_sel_hi, src_sel_lo} = sel;
    pin_in = pol ? 4'b0000 : 4'b1111;
    step(12);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    n_chk++;
    if (got !== 4'b0000) begin
      n_bad++; $display("FAIL R9 in reset got %b expected 0000", got);
    end
    rst_n = 1'b1;
    expect_out(1, 4'b0000, "R9 after reset");
    expect_out(6, 4'b0000, "R9 after reset");
    step(10);

    // R3: fault level, unfiltered latency
    cfg(4'd1, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_out(2, 4'b0000, "R3 before latency");
    expect_out(3, 4'b1000, "R3 fault rises");
    expect_out(5, 4'b1000, "R3 fault held");
    pin_in[0] = 1'b1; step(5);
    expect_out(2, 4'b1000, "R3 fault still high");
    expect_out(3, 4'b0000, "R3 fault clears");
    pin_in[0] = 1'b0; step(10);

    // R4: low-active polarity, mode 3, source 1
    cfg(4'd3, 1'b0, 1'b0, 1'b0, 2'd1);
    expect_out(3, 4'b1000, "R4 low level active");
    pin_in[1] = 1'b0; step(6);
    expect_out(3, 4'b0000, "R4 high level inactive");
    pin_in[1] = 1'b1; step(10);

    // R1: mode 0 ignores input
    cfg(4'd0, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_out(3, 4'b0000, "R1 mode0 edge");
    expect_out(5, 4'b0000, "R1 mode0 level");
    pin_in[0] = 1'b1; step(8); pin_in[0] = 1'b0; step(8);

    // R2: undefined mode 12
    cfg(4'd12, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_out(3, 4'b0000, "R2 undef edge");
    expect_out(5, 4'b0000, "R2 undef level");
    pin_in[0] = 1'b1; step(8); pin_in[0] = 1'b0; step(8);

    // R5: mode 8 retrigger
    cfg(4'd8, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_out(2, 4'b0000, "R5 mode8 before");
    expect_out(3, 4'b0100, "R5 mode8 pulse");
    expect_out(4, 4'b0000, "R5 mode8 one cycle");
    pin_in[0] = 1'b1; step(8);
    expect_out(3, 4'b0000, "R5 mode8 no pulse on release");
    pin_in[0] = 1'b0; step(8);

    // R5 + R4: mode 9, falling edge active
    cfg(4'd9, 1'b0, 1'b0, 1'b0, 2'd0);
    expect_out(3, 4'b0110, "R5 mode9 pulse fixed");
    expect_out(4, 4'b0010, "R5 mode9 one cycle");
    pin_in[0] = 1'b0; step(8); pin_in[0] = 1'b1; step(8);

    // R7: capture in mode 0
    cfg(4'd0, 1'b1, 1'b0, 1'b1, 2'd0);
    expect_out(3, 4'b0001, "R7 capture strobe");
    expect_out(4, 4'b0000, "R7 capture one cycle");
    pin_in[0] = 1'b1; step(8); pin_in[0] = 1'b0; step(8);

    // R7: capture disabled in mode 8
    cfg(4'd8, 1'b1, 1'b0, 1'b0, 2'd0);
    expect_out(3, 4'b0100, "R7 no capture when disabled");
    pin_in[0] = 1'b1; step(8); pin_in[0] = 1'b0; step(8);

    // R6: filter delays by four cycles
    cfg(4'd1, 1'b1, 1'b1, 1'b0, 2'd0);
    expect_out(3, 4'b0000, "R6 filtered early");
    expect_out(6, 4'b0000, "R6 filtered early");
    expect_out(7, 4'b1000, "R6 filtered accept");
    pin_in[0] = 1'b1; step(12);
    expect_out(6, 4'b1000, "R6 filtered release hold");
    expect_out(7, 4'b0000, "R6 filtered release");
    pin_in[0] = 1'b0; step(12);
    // R6: three-cycle glitch suppressed
    for (int d = 2; d <= 11; d++) expect_out(d, 4'b0000, "R6 glitch suppressed");
    pin_in[0] = 1'b1; step(3); pin_in[0] = 1'b0; step(12);
    // R6: filtered retrigger
    cfg(4'd8, 1'b1, 1'b1, 1'b1, 2'd0);
    expect_out(6, 4'b0000, "R6 filtered pulse early");
    expect_out(7, 4'b0101, "R6 filtered pulse");
    expect_out(8, 4'b0000, "R6 filtered pulse one cycle");
    pin_in[0] = 1'b1; step(12); pin_in[0] = 1'b0; step(12);

    // R8: source 2 selected, others ignored
    cfg(4'd1, 1'b1, 1'b0, 1'b0, 2'd2);
    expect_out(4, 4'b0000, "R8 unselected pins ignored");
    pin_in = 4'b1011; step(8);
    expect_out(3, 4'b1000, "R8 selected pin2");
    pin_in = 4'b0100; step(8);
    expect_out(3, 4'b1000, "R8 other pins no effect");
    pin_in = 4'b1111; step(8);
    pin_in = 4'b0000; step(8);

    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule